// File: doc/BRIEF.md
# Eight-Mode Universal Shift Register

This block is a small clocked register, four bits wide by default, that performs one of eight operations on every rising clock edge. A 3-bit mode input selects the operation: keep the current value, load a parallel word, or shift one place right or left. Shifts come in circular, logical and arithmetic forms. One mode decoder is shared by all bits. Each bit is an identical cell holding one flip-flop and a four-way selector. The selector picks the bit's own value, its upper neighbour, its lower neighbour, or the parallel data bit.

The decoder turns the 3-bit mode into a 2-bit cell select. It also raises three end-fill flags, gated by a decoder enable. These flags decide what enters the bit left empty by a shift. When the enable is low, circular and arithmetic shifts fall back to zero-filling logical shifts. A synchronous active-high reset clears the register ahead of every mode. Integration is simple: drive a mode and data word, and read the register state one cycle later. All pins are plain control and data; there is no handshake.

Top module: `ushift8_reg`

## Requirements
- R1: While `rst` is 1 at a rising edge, `q_out` becomes all zeros on that edge, whatever `mode`, `dec_en` and `par_in` are.
- R2: Mode code 3'b000 (keep) leaves `q_out` unchanged across the edge.
- R3: Mode code 3'b111 (load) copies `par_in` into `q_out` on the edge.
- R4: Mode codes 3'b001, 3'b011 and 3'b101 (right shifts) move every bit one place toward bit 0: new bit i equals old bit i+1 for i below the top bit.
- R5: Mode codes 3'b010, 3'b100 and 3'b110 (left shifts) move every bit one place toward the top bit: new bit i equals old bit i-1 for i above 0.
- R6: With `dec_en` at 1, mode 3'b001 (circular right) puts old bit 0 into the top bit.
- R7: With `dec_en` at 1, mode 3'b010 (circular left) puts old top bit into bit 0.
- R8: Mode 3'b011 (logical right) fills the top bit with 0. Modes 3'b100 (logical left) and 3'b110 (arithmetic left) fill bit 0 with 0, whatever the value of `dec_en`.
- R9: With `dec_en` at 1, mode 3'b101 (arithmetic right) keeps the top bit at its old value.
- R10: With `dec_en` at 0, modes 3'b001 and 3'b101 fill the top bit with 0, and mode 3'b010 fills bit 0 with 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| dec_en | input | 1 | Enables the circular and sign end-fill flags of the decoder |
| mode | input | 3 | Operation select, encoded as listed in the requirements |
| par_in | input | W (4) | Parallel data word for the load mode |
| q_out | output | W (4) | Register state, bit W-1 is the top bit |

## Verification
The hardest cases to reach are the end-fill bits. They depend at once on the mode, on `dec_en` and on the old value of the bit that wraps or repeats. A fault such as a flag that ignores the enable only shows up when the old end bit is 1 and the enable is low. The bench therefore preloads every one of the sixteen register states with the load mode. From each state it applies every mode under both enable values, with a parallel word that differs from the state, so each fill source is seen at both levels.

// File: rtl/ushift8_pkg.sv
package ushift8_pkg;

  typedef enum logic [2:0] {
    MODE_KEEP  = 3'b000,
    MODE_ROT_R = 3'b001,
    MODE_ROT_L = 3'b010,
    MODE_LOG_R = 3'b011,
    MODE_LOG_L = 3'b100,
    MODE_ARI_R = 3'b101,
    MODE_ARI_L = 3'b110,
    MODE_LOAD  = 3'b111
  } shift_mode_e;

  // Cell select: 01 takes the upper neighbour (right shift), 10 the lower one.
  typedef enum logic [1:0] {
    CSEL_KEEP    = 2'b00,
    CSEL_FROM_UP = 2'b01,
    CSEL_FROM_DN = 2'b10,
    CSEL_PAR     = 2'b11
  } cell_sel_e;

endpackage

// File: rtl/ushift8_mode_dec.sv
module ushift8_mode_dec
  import ushift8_pkg::*;
(
  input  logic [2:0] mode_raw,
  input  logic       en,
  output cell_sel_e  sel,
  output logic       rot_r,
  output logic       rot_l,
  output logic       sign_r
);

  shift_mode_e md;

  always_comb begin
    md     = shift_mode_e'(mode_raw);
    rot_r  = en & (md == MODE_ROT_R);
    rot_l  = en & (md == MODE_ROT_L);
    sign_r = en & (md == MODE_ARI_R);
    unique case (md)
      MODE_KEEP:                          sel = CSEL_KEEP;
      MODE_ROT_R, MODE_LOG_R, MODE_ARI_R: sel = CSEL_FROM_UP;
      MODE_ROT_L, MODE_LOG_L, MODE_ARI_L: sel = CSEL_FROM_DN;
      MODE_LOAD:                          sel = CSEL_PAR;
      default:                            sel = CSEL_KEEP;
    endcase
  end

endmodule

// File: rtl/ushift8_edge_fill.sv
module ushift8_edge_fill #(
  parameter int W = 4
) (
  input  logic [W-1:0] q,
  input  logic         rot_r,
  input  logic         rot_l,
  input  logic         sign_r,
  output logic         top_fill,
  output logic         bot_fill
);

  localparam int TOP = W - 1;

  always_comb begin
    // Vacated top bit on a right shift: wrap, sign copy, or zero.
    top_fill = (rot_r & q[0]) | (sign_r & q[TOP]);
    // Vacated bottom bit on a left shift: wrap or zero.
    bot_fill = rot_l & q[TOP];
  end

endmodule

// File: rtl/ushift8_cell.sv
module ushift8_cell
  import ushift8_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  cell_sel_e sel,
  input  logic      from_up,
  input  logic      from_dn,
  input  logic      par_bit,
  output logic      q
);

  logic d_nxt;

  always_comb begin
    unique case (sel)
      CSEL_KEEP:    d_nxt = q;
      CSEL_FROM_UP: d_nxt = from_up;
      CSEL_FROM_DN: d_nxt = from_dn;
      CSEL_PAR:     d_nxt = par_bit;
      default:      d_nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d_nxt;
  end

endmodule

// File: rtl/ushift8_reg.sv
module ushift8_reg
  import ushift8_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dec_en,
  input  logic [2:0]   mode,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] q_out
);

  localparam int TOP = W - 1;

  cell_sel_e sel;
  logic      rot_r, rot_l, sign_r;
  logic      top_fill, bot_fill;

  ushift8_mode_dec dec_i (
    .mode_raw (mode),
    .en       (dec_en),
    .sel      (sel),
    .rot_r    (rot_r),
    .rot_l    (rot_l),
    .sign_r   (sign_r)
  );

  ushift8_edge_fill #(.W(W)) fill_i (
    .q        (q_out),
    .rot_r    (rot_r),
    .rot_l    (rot_l),
    .sign_r   (sign_r),
    .top_fill (top_fill),
    .bot_fill (bot_fill)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic up_src, dn_src;
    if (i == TOP) begin : g_top
      assign up_src = top_fill;
    end else begin : g_mid_up
      assign up_src = q_out[i+1];
    end
    if (i == 0) begin : g_bot
      assign dn_src = bot_fill;
    end else begin : g_mid_dn
      assign dn_src = q_out[i-1];
    end
    ushift8_cell cell_i (
      .clk     (clk),
      .rst     (rst),
      .sel     (sel),
      .from_up (up_src),
      .from_dn (dn_src),
      .par_bit (par_in[i]),
      .q       (q_out[i])
    );
  end

endmodule

// File: rtl/ushift8_reg_chk.sv
module ushift8_reg_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         dec_en,
  input logic [2:0]   mode,
  input logic [W-1:0] par_in,
  input logic [W-1:0] q_out
);

  localparam int TOP = W - 1;

  logic seen_clk = 1'b0;
  logic rst_d    = 1'b0;

  always_ff @(posedge clk) begin
    seen_clk <= 1'b1;
    rst_d    <= rst;
  end

  // R1: a reset edge leaves the register cleared
  always @(negedge clk) begin
    if (seen_clk && rst_d) begin
      a_r1_reset_clears: assert (q_out == '0);
    end
  end

  a_r2_keep_stable: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'b000) |=> $stable(q_out));

  a_r3_load_copies: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'b111) |=> (q_out == $past(par_in)));

  a_r4_right_body: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'b001 || mode == 3'b011 || mode == 3'b101)
      |=> (q_out[TOP-1:0] == $past(q_out[TOP:1])));

  a_r5_left_body: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'b010 || mode == 3'b100 || mode == 3'b110)
      |=> (q_out[TOP:1] == $past(q_out[TOP-1:0])));

  a_r6_rot_right_wrap: assert property (@(posedge clk) disable iff (rst)
    (dec_en && mode == 3'b001) |=> (q_out[TOP] == $past(q_out[0])));

  a_r7_rot_left_wrap: assert property (@(posedge clk) disable iff (rst)
    (dec_en && mode == 3'b010) |=> (q_out[0] == $past(q_out[TOP])));

  a_r8_logic_right_zero: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'b011) |=> (q_out[TOP] == 1'b0));

  a_r8_left_zero: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'b100 || mode == 3'b110) |=> (q_out[0] == 1'b0));

  a_r9_sign_kept: assert property (@(posedge clk) disable iff (rst)
    (dec_en && mode == 3'b101) |=> $stable(q_out[TOP]));

  a_r10_off_right_zero: assert property (@(posedge clk) disable iff (rst)
    (!dec_en && (mode == 3'b001 || mode == 3'b101)) |=> (q_out[TOP] == 1'b0));

  a_r10_off_left_zero: assert property (@(posedge clk) disable iff (rst)
    (!dec_en && mode == 3'b010) |=> (q_out[0] == 1'b0));

endmodule

bind ushift8_reg ushift8_reg_chk #(.W(W)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .dec_en (dec_en),
  .mode   (mode),
  .par_in (par_in),
  .q_out  (q_out)
);

// File: tb/ushift8_reg_tb_top.sv
module ushift8_reg_tb_top;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         dec_en = 1'b0;
  logic [2:0]   mode = 3'b000;
  logic [W-1:0] par_in = '0;
  logic [W-1:0] q_out;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  ushift8_reg #(.W(W)) dut_i (
    .clk    (clk),
    .rst    (rst),
    .dec_en (dec_en),
    .mode   (mode),
    .par_in (par_in),
    .q_out  (q_out)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] s, input logic [2:0] m,
                                         input logic e, input logic [W-1:0] d);
    logic [W-1:0] r;
    case (m)
      3'd0: r = s;
      3'd1: r = (s >> 1) | ((e ? s[0] : 1'b0) ? (1 << (W-1)) : 0);
      3'd2: r = (s << 1) | ((e ? s[W-1] : 1'b0) ? 1 : 0);
      3'd3: r = s >> 1;
      3'd4: r = s << 1;
      3'd5: r = (s >> 1) | ((e ? s[W-1] : 1'b0) ? (1 << (W-1)) : 0);
      3'd6: r = s << 1;
      default: r = d;
    endcase
    return r;
  endfunction

  function automatic string req_of(input logic [2:0] m, input logic e);
    case (m)
      3'd0: return "R2";
      3'd7: return "R3";
      3'd1: return e ? "R6" : "R10";
      3'd2: return e ? "R7" : "R10";
      3'd5: return e ? "R9" : "R10";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic apply(input logic r, input logic [2:0] m, input logic e, input logic [W-1:0] d);
    rst = r; mode = m; dec_en = e; par_in = d;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    apply(1'b1, 3'b111, 1'b1, 4'hF);
    check("R1", q_out, '0);
    apply(1'b0, 3'b111, 1'b0, 4'hA);
    check("R3", q_out, 4'hA);
    // R1: reset wins over a load request
    apply(1'b1, 3'b111, 1'b1, 4'h5);
    check("R1", q_out, '0);

    for (int s = 0; s < (1 << W); s++) begin
      for (int m = 0; m < 8; m++) begin
        for (int e = 0; e < 2; e++) begin
          logic [W-1:0] st, d, ex;
          st = W'(s);
          d  = ~st ^ W'(m);
          apply(1'b0, 3'b111, 1'b0, st);
          check("R3", q_out, st);
          ex = model(st, 3'(m), e[0], d);
          apply(1'b0, 3'(m), e[0], d);
          check(req_of(3'(m), e[0]), q_out, ex);
          if (m == 1 || m == 3 || m == 5)
            check("R4", {1'b0, q_out[W-2:0]}, {1'b0, st[W-1:1]});
          if (m == 2 || m == 4 || m == 6)
            check("R5", {q_out[W-1:1], 1'b0}, {st[W-2:0], 1'b0});
        end
      end
    end

    // R2: keep holds across several edges with changing data
    apply(1'b0, 3'b111, 1'b0, 4'h9);
    for (int k = 0; k < 4; k++) begin
      apply(1'b0, 3'b000, k[0], W'(k * 3));
      check("R2", q_out, 4'h9);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule